// File: doc/BRIEF.md
# Banked Configuration Register Store

This block keeps the live configuration bytes of a converter front end together with a larger scratch memory that holds saved configuration images. The live set is 16 bytes wide. The scratch memory holds 128 bytes, grouped as eight banks of 16 bytes. A serial command decoder drives the block through a single request port. Each request carries an opcode, a 7-bit address operand and a write byte. The block answers with an acknowledge pulse and a read byte.

Single-byte commands finish in one cycle. They can write or read a live register, load the memory pointer, or write or read the memory at the pointer. Each memory access advances the pointer by one. Because the pointer is linear, it runs straight across bank boundaries and wraps at the top of the memory. The memory is also usable as plain storage that the live registers never see.

Three commands run for several cycles. Two of them copy a whole bank, one byte per cycle, either from memory into the live registers or from the live registers into memory. The third adds up the bytes of one bank, or of the whole memory, modulo 256. While one of these commands runs, the block reports busy. Any request made while busy is dropped and produces a one-cycle error pulse.

Top module: `cfg_bank_store`

## Requirements
- R1: After reset, live register 0 holds 0x01, live register 1 holds 0x08 and all other live registers hold 0x00. The memory pointer is 0. `busy`, `ack`, `err` and `rdata` are all 0. Memory contents are not defined by reset.
- R2: Opcode 0 writes `req_wdata` to live register `req_addr[3:0]`. Opcode 1 reads that register into `rdata`. Every accepted single-cycle command pulses `ack` in the cycle after it is accepted, and a read presents its byte on `rdata` in that same cycle.
- R3: Opcode 2 loads the pointer from `req_addr`. Opcode 3 writes `req_wdata` to memory at the pointer. Opcode 4 reads memory at the pointer into `rdata`. Opcodes 3 and 4 each advance the pointer by one.
- R4: A memory address splits into a bank number in bits [6:4] and an offset in bits [3:0]. Advancing from offset 0xF moves to offset 0 of the next bank, and advancing from 0x7F wraps to 0x00.
- R5: Memory writes leave the live registers unchanged, and live register writes leave the memory unchanged.
- R6: Opcode 5 copies memory bank `req_addr[6:4]` into the live registers, placing offset k in register k.
- R7: Opcode 6 copies all 16 live registers into memory bank `req_addr[6:4]`, placing register k at offset k.
- R8: A bank copy holds `busy` high for exactly 16 cycles. `ack` never coincides with `busy`, and it pulses in the cycle that `busy` falls.
- R9: Opcode 7 returns on `rdata`, with its `ack`, the modulo-256 sum of bank `req_addr[6:4]` when `req_addr[0]` is 0, taking 16 busy cycles. When `req_addr[0]` is 1 it returns the sum of all 128 bytes, taking 128 busy cycles.
- R10: A request made while `busy` is high is ignored: it changes no register, memory byte or pointer. It raises `err` for exactly one cycle, the following one.
- R11: Bank copies and checksums leave the memory pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 3 | Command opcode, 0 to 7 |
| req_addr | input | 7 | Register index, pointer value, bank in [6:4], checksum scope in [0] |
| req_wdata | input | 8 | Byte to write |
| ack | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Result of the most recent read or checksum |
| busy | output | 1 | Multi-cycle command in progress |
| err | output | 1 | One-cycle pulse: a request arrived while busy |

## Verification
A pointer that advances wrongly or fails to wrap shows up on the very next memory read. That read returns a byte written at a different address, because the bench first fills every location with a distinct value. A copy engine with a bad counter or base address leaves a busy window of the wrong length, which is visible when `busy` falls. It also leaves misplaced bytes, which appear when the copied bank or register set is read back a few commands later. A dropped-request guard that leaks its command shows up as a changed live register when that register is next read. A checksum accumulator that starts from a stale value returns a wrong sum with its acknowledge.

// File: rtl/cfg_bank_pkg.sv
package cfg_bank_pkg;

    typedef enum logic [2:0] {
        OP_REG_WR    = 3'd0,
        OP_REG_RD    = 3'd1,
        OP_PTR_SET   = 3'd2,
        OP_RAM_WR    = 3'd3,
        OP_RAM_RD    = 3'd4,
        OP_BANK_LOAD = 3'd5,
        OP_BANK_SAVE = 3'd6,
        OP_CHECKSUM  = 3'd7
    } cfg_op_e;

    typedef enum logic [1:0] {
        ENG_IDLE = 2'd0,
        ENG_LOAD = 2'd1,
        ENG_SAVE = 2'd2,
        ENG_SUM  = 2'd3
    } eng_mode_e;

endpackage

// File: rtl/cfg_reg_file.sv
module cfg_reg_file #(
    parameter int DW = 8,
    parameter int NREG = 16,
    parameter logic [NREG*DW-1:0] INIT = '0,
    localparam int OW = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [OW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [OW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] regs_q [NREG];
    logic [DW-1:0] regs_d [NREG];

    always_comb begin
        for (int i = 0; i < NREG; i++) begin
            regs_d[i] = regs_q[i];
        end
        if (we) begin
            regs_d[waddr] = wdata;
        end
    end

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                regs_q[g] <= INIT[g*DW +: DW];
            end else begin
                regs_q[g] <= regs_d[g];
            end
        end
    end

    assign rdata = regs_q[raddr];

endmodule

// File: rtl/cfg_ram_store.sv
module cfg_ram_store #(
    parameter int DW = 8,
    parameter int DEPTH = 128,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] mem_q [DEPTH];

    // Storage carries no reset; its contents after reset are undefined.
    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];

endmodule

// File: rtl/cfg_bank_ctrl.sv
module cfg_bank_ctrl
    import cfg_bank_pkg::*;
#(
    parameter int DW = 8,
    parameter int NREG = 16,
    parameter int NBANK = 8,
    localparam int OW = $clog2(NREG),
    localparam int BW = $clog2(NBANK),
    localparam int AW = OW + BW,
    localparam int DEPTH = NREG * NBANK
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [2:0]    req_op,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          ack,
    output logic [DW-1:0] rdata,
    output logic          busy,
    output logic          err,
    output logic          reg_we,
    output logic [OW-1:0] reg_waddr,
    output logic [DW-1:0] reg_wdata,
    output logic [OW-1:0] reg_raddr,
    input  logic [DW-1:0] reg_rdata,
    output logic          ram_we,
    output logic [AW-1:0] ram_waddr,
    output logic [DW-1:0] ram_wdata,
    output logic [AW-1:0] ram_raddr,
    input  logic [DW-1:0] ram_rdata
);

    localparam logic [AW-1:0] LAST_BANK = AW'(NREG - 1);
    localparam logic [AW-1:0] LAST_ALL  = AW'(DEPTH - 1);

    typedef struct packed {
        eng_mode_e     mode;
        logic [AW-1:0] ptr;
        logic [AW-1:0] cnt;
        logic [AW-1:0] last;
        logic [AW-1:0] base;
        logic [DW-1:0] sum;
        logic          ack;
        logic [DW-1:0] rdata;
        logic          err;
    } ctrl_t;

    ctrl_t         s_d, s_q;
    logic [AW-1:0] eng_addr;
    logic [AW-1:0] bank_base;
    cfg_op_e       op;

    assign op        = cfg_op_e'(req_op);
    assign eng_addr  = s_q.base + s_q.cnt;
    assign bank_base = {req_addr[AW-1:OW], {OW{1'b0}}};

    always_comb begin
        s_d       = s_q;
        s_d.ack   = 1'b0;
        s_d.err   = 1'b0;
        reg_we    = 1'b0;
        reg_waddr = req_addr[OW-1:0];
        reg_wdata = req_wdata;
        reg_raddr = req_addr[OW-1:0];
        ram_we    = 1'b0;
        ram_waddr = s_q.ptr;
        ram_wdata = req_wdata;
        ram_raddr = s_q.ptr;

        if (s_q.mode != ENG_IDLE) begin
            // engine step: one byte per cycle, requests are refused
            s_d.err   = req_valid;
            reg_raddr = s_q.cnt[OW-1:0];
            ram_raddr = eng_addr;
            case (s_q.mode)
                ENG_LOAD: begin
                    reg_we    = 1'b1;
                    reg_waddr = s_q.cnt[OW-1:0];
                    reg_wdata = ram_rdata;
                end
                ENG_SAVE: begin
                    ram_we    = 1'b1;
                    ram_waddr = eng_addr;
                    ram_wdata = reg_rdata;
                end
                ENG_SUM: begin
                    s_d.sum = s_q.sum + ram_rdata;
                end
                default: begin
                end
            endcase
            s_d.cnt = s_q.cnt + AW'(1);
            if (s_q.cnt == s_q.last) begin
                s_d.mode = ENG_IDLE;
                s_d.ack  = 1'b1;
                if (s_q.mode == ENG_SUM) begin
                    s_d.rdata = s_q.sum + ram_rdata;
                end
            end
        end else if (req_valid) begin
            s_d.ack = 1'b1;
            case (op)
                OP_REG_WR: begin
                    reg_we = 1'b1;
                end
                OP_REG_RD: begin
                    s_d.rdata = reg_rdata;
                end
                OP_PTR_SET: begin
                    s_d.ptr = req_addr;
                end
                OP_RAM_WR: begin
                    ram_we  = 1'b1;
                    s_d.ptr = s_q.ptr + AW'(1);
                end
                OP_RAM_RD: begin
                    s_d.rdata = ram_rdata;
                    s_d.ptr   = s_q.ptr + AW'(1);
                end
                OP_BANK_LOAD, OP_BANK_SAVE: begin
                    s_d.ack  = 1'b0;
                    s_d.mode = (op == OP_BANK_LOAD) ? ENG_LOAD : ENG_SAVE;
                    s_d.cnt  = '0;
                    s_d.base = bank_base;
                    s_d.last = LAST_BANK;
                end
                OP_CHECKSUM: begin
                    s_d.ack  = 1'b0;
                    s_d.mode = ENG_SUM;
                    s_d.cnt  = '0;
                    s_d.sum  = '0;
                    if (req_addr[0]) begin
                        s_d.base = '0;
                        s_d.last = LAST_ALL;
                    end else begin
                        s_d.base = bank_base;
                        s_d.last = LAST_BANK;
                    end
                end
                default: begin
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign ack   = s_q.ack;
    assign rdata = s_q.rdata;
    assign busy  = (s_q.mode != ENG_IDLE);
    assign err   = s_q.err;

endmodule

// File: rtl/cfg_bank_store.sv
module cfg_bank_store #(
    parameter int DW = 8,
    parameter int NREG = 16,
    parameter int NBANK = 8,
    parameter logic [NREG*DW-1:0] REG_INIT = 128'h0801,
    localparam int OW = $clog2(NREG),
    localparam int BW = $clog2(NBANK),
    localparam int AW = OW + BW,
    localparam int DEPTH = NREG * NBANK
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [2:0]    req_op,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          ack,
    output logic [DW-1:0] rdata,
    output logic          busy,
    output logic          err
);

    logic          reg_we;
    logic [OW-1:0] reg_waddr;
    logic [DW-1:0] reg_wdata;
    logic [OW-1:0] reg_raddr;
    logic [DW-1:0] reg_rdata;
    logic          ram_we;
    logic [AW-1:0] ram_waddr;
    logic [DW-1:0] ram_wdata;
    logic [AW-1:0] ram_raddr;
    logic [DW-1:0] ram_rdata;

    cfg_bank_ctrl #(.DW(DW), .NREG(NREG), .NBANK(NBANK)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_op    (req_op),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .ack       (ack),
        .rdata     (rdata),
        .busy      (busy),
        .err       (err),
        .reg_we    (reg_we),
        .reg_waddr (reg_waddr),
        .reg_wdata (reg_wdata),
        .reg_raddr (reg_raddr),
        .reg_rdata (reg_rdata),
        .ram_we    (ram_we),
        .ram_waddr (ram_waddr),
        .ram_wdata (ram_wdata),
        .ram_raddr (ram_raddr),
        .ram_rdata (ram_rdata)
    );

    cfg_reg_file #(.DW(DW), .NREG(NREG), .INIT(REG_INIT)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (reg_we),
        .waddr (reg_waddr),
        .wdata (reg_wdata),
        .raddr (reg_raddr),
        .rdata (reg_rdata)
    );

    cfg_ram_store #(.DW(DW), .DEPTH(DEPTH)) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .waddr (ram_waddr),
        .wdata (ram_wdata),
        .raddr (ram_raddr),
        .rdata (ram_rdata)
    );

endmodule

// File: rtl/cfg_bank_checker.sv
module cfg_bank_checker #(
    parameter int DEPTH = 128,
    localparam int CW = $clog2(DEPTH) + 2
) (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic busy,
    input logic ack,
    input logic err,
    input logic reg_we,
    input logic ram_we
);

    logic [CW-1:0] run_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_len <= '0;
        end else if (busy) begin
            run_len <= run_len + CW'(1);
        end else begin
            run_len <= '0;
        end
    end

    assert_ack_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> $past(busy || req_valid));

    assert_ack_not_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !ack);

    assert_fall_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ack);

    assert_busy_bounded_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (run_len < CW'(DEPTH)));

    assert_err_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> $past(req_valid && busy));

    assert_single_target_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_we && ram_we));

endmodule

bind cfg_bank_store cfg_bank_checker #(.DEPTH(NREG * NBANK)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .busy      (busy),
    .ack       (ack),
    .err       (err),
    .reg_we    (reg_we),
    .ram_we    (ram_we)
);

// File: tb/sim_cfg_bank_store.sv
module sim_cfg_bank_store;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       req_valid;
    logic [2:0] req_op;
    logic [6:0] req_addr;
    logic [7:0] req_wdata;
    logic       ack;
    logic [7:0] rdata;
    logic       busy;
    logic       err;

    always #10 clk = ~clk;

    cfg_bank_store u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_op    (req_op),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .ack       (ack),
        .rdata     (rdata),
        .busy      (busy),
        .err       (err)
    );

    typedef struct {
        bit         chk;
        logic [7:0] exp;
        string      tag;
    } exp_t;

    exp_t       sb[$];
    int         n_tests = 0;
    int         n_fail = 0;
    int         busy_run = 0;
    int         last_run = 0;
    int         err_cycles = 0;
    logic [7:0] m_reg [16];
    logic [7:0] m_ram [128];
    logic [6:0] m_ptr;

    function automatic void check(string tag, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endfunction

    // monitor / scoreboard
    always @(negedge clk) begin
        exp_t e;
        if (rst_n) begin
            if (busy) busy_run++;
            else if (busy_run != 0) begin
                last_run = busy_run;
                busy_run = 0;
            end
            if (err) err_cycles++;
            if (ack) begin
                if (sb.size() == 0) begin
                    check("R2 ack with nothing pending", 1, 0);
                end else begin
                    e = sb.pop_front();
                    if (e.chk) check(e.tag, int'(rdata), int'(e.exp));
                end
            end
        end
    end

    function automatic exp_t model(logic [2:0] op, logic [6:0] addr, logic [7:0] wd, string tag);
        exp_t       e;
        logic [7:0] s;
        e.chk = 1'b0;
        e.exp = 8'h00;
        e.tag = tag;
        case (op)
            3'd0: m_reg[addr[3:0]] = wd;
            3'd1: begin e.chk = 1'b1; e.exp = m_reg[addr[3:0]]; end
            3'd2: m_ptr = addr;
            3'd3: begin m_ram[m_ptr] = wd; m_ptr++; end
            3'd4: begin e.chk = 1'b1; e.exp = m_ram[m_ptr]; m_ptr++; end
            3'd5: for (int k = 0; k < 16; k++) m_reg[k] = m_ram[{addr[6:4], 4'(k)}];
            3'd6: for (int k = 0; k < 16; k++) m_ram[{addr[6:4], 4'(k)}] = m_reg[k];
            default: begin
                s = 8'h00;
                if (addr[0]) for (int k = 0; k < 128; k++) s += m_ram[k];
                else for (int k = 0; k < 16; k++) s += m_ram[{addr[6:4], 4'(k)}];
                e.chk = 1'b1;
                e.exp = s;
            end
        endcase
        return e;
    endfunction

    // driver: called at posedge + 2 ns, returns at posedge + 2 ns
    task automatic cmd(input logic [2:0] op, input logic [6:0] addr, input logic [7:0] wd, input string tag);
        while (busy) begin @(posedge clk); #2; end
        sb.push_back(model(op, addr, wd, tag));
        req_valid = 1'b1; req_op = op; req_addr = addr; req_wdata = wd;
        @(posedge clk); #2;
        req_valid = 1'b0;
        while (sb.size() != 0) begin @(posedge clk); #2; end
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        #(20 * 200000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin
        int e0;
        rst_n = 1'b0; req_valid = 1'b0; req_op = 3'd0; req_addr = 7'd0; req_wdata = 8'd0;
        for (int k = 0; k < 16; k++) m_reg[k] = 8'h00;
        m_reg[0] = 8'h01;
        m_reg[1] = 8'h08;
        m_ptr = 7'd0;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        check("R1 busy after reset", int'(busy), 0);
        check("R1 ack after reset", int'(ack), 0);
        check("R1 err after reset", int'(err), 0);
        check("R1 rdata after reset", int'(rdata), 0);
        @(posedge clk); #2;

        // R1: pointer starts at 0, registers at defaults
        cmd(3'd3, 7'd0, 8'h5A, "R1 write at reset pointer");
        cmd(3'd2, 7'd0, 8'h00, "R3 pointer set");
        cmd(3'd4, 7'd0, 8'h00, "R1 pointer reset to 0");
        for (int i = 0; i < 16; i++) cmd(3'd1, 7'(i), 8'h00, "R1 register default");

        // R2: live register write/read
        cmd(3'd0, 7'd3, 8'hC3, "R2 write");
        cmd(3'd0, 7'd15, 8'h3C, "R2 write");
        cmd(3'd1, 7'd3, 8'h00, "R2 read reg 3");
        cmd(3'd1, 7'd15, 8'h00, "R2 read reg 15");

        // R3 / R4: fill all memory linearly, pointer wraps back to 0
        cmd(3'd2, 7'd0, 8'h00, "R3 pointer set");
        for (int i = 0; i < 128; i++) cmd(3'd3, 7'd0, 8'(i * 37 + 11), "R3 fill");
        cmd(3'd4, 7'd0, 8'h00, "R4 wrap after 128 writes");
        cmd(3'd2, 7'h7F, 8'h00, "R3 pointer set");
        cmd(3'd4, 7'd0, 8'h00, "R4 read at 0x7F");
        cmd(3'd4, 7'd0, 8'h00, "R4 wrap 0x7F to 0x00");
        cmd(3'd2, 7'h0E, 8'h00, "R3 pointer set");
        cmd(3'd4, 7'd0, 8'h00, "R4 read at 0x0E");
        cmd(3'd4, 7'd0, 8'h00, "R4 read at 0x0F");
        cmd(3'd4, 7'd0, 8'h00, "R4 cross into bank 1");
        cmd(3'd2, 7'h14, 8'h00, "R3 pointer set");
        cmd(3'd4, 7'd0, 8'h00, "R3 read bank 1 offset 4");

        // R5: registers untouched by memory traffic
        for (int i = 0; i < 16; i++) cmd(3'd1, 7'(i), 8'h00, "R5 register kept");

        // R9: checksums
        cmd(3'd7, 7'h20, 8'h00, "R9 bank 2 sum");
        check("R9 bank sum busy length", last_run, 16);
        cmd(3'd7, 7'h01, 8'h00, "R9 whole memory sum");
        check("R9 whole sum busy length", last_run, 128);

        // R7 / R8 / R11: save registers into bank 5
        for (int i = 0; i < 16; i++) cmd(3'd0, 7'(i), 8'(8'hA0 + i), "R2 write");
        cmd(3'd2, 7'h33, 8'h00, "R3 pointer set");
        cmd(3'd6, 7'h50, 8'h00, "R7 save");
        check("R8 save busy length", last_run, 16);
        cmd(3'd4, 7'd0, 8'h00, "R11 pointer kept over copy");
        cmd(3'd2, 7'h50, 8'h00, "R3 pointer set");
        for (int i = 0; i < 16; i++) cmd(3'd4, 7'd0, 8'h00, "R7 saved byte");

        // R6: load bank 3 into registers
        cmd(3'd6 - 3'd1, 7'h30, 8'h00, "R6 load");
        check("R8 load busy length", last_run, 16);
        for (int i = 0; i < 16; i++) cmd(3'd1, 7'(i), 8'h00, "R6 loaded register");

        // R10: request during a checksum is dropped with one err pulse
        sb.push_back(model(3'd7, 7'h01, 8'h00, "R9 sum under refused request"));
        req_valid = 1'b1; req_op = 3'd7; req_addr = 7'h01; req_wdata = 8'h00;
        @(posedge clk); #2;
        req_valid = 1'b0;
        repeat (3) begin @(posedge clk); #2; end
        e0 = err_cycles;
        req_valid = 1'b1; req_op = 3'd0; req_addr = 7'd5; req_wdata = 8'hEE;
        @(posedge clk); #2;
        req_valid = 1'b0;
        while (sb.size() != 0) begin @(posedge clk); #2; end
        check("R10 err pulse count", err_cycles - e0, 1);
        cmd(3'd1, 7'd5, 8'h00, "R10 refused write had no effect");
        cmd(3'd4, 7'd0, 8'h00, "R11 pointer kept over checksum");

        summary();
        $finish;
    end

endmodule